// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog

This block watches a small CPU bus and resets the system when software stops proving that it is alive. A free-running prescaler divides the clock into ticks, and a timeout counter counts those ticks. When the counter reaches the period chosen by a rate input, the block emits a single-cycle reset pulse. After that pulse, and after a power-on reset, the prescaler and the counter start again from zero.

Software services the watchdog by writing to the top byte of the address space, 0xFFFF. The data value does not matter, so the block has no write-data input. The same address also holds the low byte of the reset vector. For that reason, reads of 0xFFFF are answered by the block with a fixed vector byte, and those reads leave the counter untouched. A vector-fetch indication on either reset-vector address clears the prescaler. The watchdog is held cleared and idle while a configuration disable bit is set or while the system is in monitor mode. It keeps counting in every other state, including CPU wait states. The block never requests an interrupt.

The read response is a stream output: `rd_valid` carries one beat per qualifying read, one cycle after the read strobe. The block cannot stall it, so the consumer must accept every beat in that cycle and no back-pressure exists. All other pins are plain level or strobe signals, sampled on the rising clock edge.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `cop_reset` and `rd_valid` are 0.
- R2: With `cfg_long`=0, the watchdog active and the bus idle, `cop_reset` rises after exactly 2^PRESCALE_W × 2^SHORT_EXP rising edges, counted from the first edge after reset release. It stays high for one cycle only.
- R3: With `cfg_long`=1, the same count is 2^PRESCALE_W × 2^LONG_EXP edges.
- R4: A cycle with `bus_wr`=1 and `bus_addr`=0xFFFF clears the timeout counter, whatever is on the data lines. Servicing more often than once per period therefore never produces a pulse.
- R5: A cycle with `bus_rd`=1 and `bus_addr`=0xFFFF makes `rd_valid`=1 with `rd_data`=VEC_LO in the next cycle, and has no effect on the timeout.
- R6: A cycle with `vec_fetch`=1 and `bus_addr` equal to 0xFFFE or 0xFFFF clears the prescaler. `vec_fetch` at any other address has no effect.
- R7: While `cfg_disable`=1, no pulse is issued and both counters are held at zero. After the bit is released, the full period of R2 or R3 runs again.
- R8: While `monitor_mode`=1, the watchdog behaves exactly as in R7.
- R9: A timeout pulse clears both counters. The next pulse follows one cycle later than a full period, counted from the pulse.
- R10: Writes to any address other than 0xFFFF, and reads of any address, do not delay a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 16 | Snooped CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| vec_fetch | input | 1 | CPU is fetching a reset vector |
| cfg_disable | input | 1 | Configuration bit: hold watchdog off |
| cfg_long | input | 1 | Configuration bit: 1 selects the long period |
| monitor_mode | input | 1 | System is in monitor mode |
| rd_data | output | 8 | Vector low byte for a read of 0xFFFF |
| rd_valid | output | 1 | rd_data beat is valid this cycle |
| cop_reset | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact edge count to the first and to the repeated timeout. A design with an extra pipeline stage, or one that fails to clear itself on its own pulse, lands off by one or keeps pulsing. Vector fetches on the vector address are issued every three cycles to show that the prescaler really clears, while fetches elsewhere must not starve it. Reads of 0xFFFF and writes to 0xFFFE must still let a timeout through: a decoder that serviced on the wrong strobe or address would hide it. Disable and monitor mode must hold the counters at zero rather than merely mask the output, which shows up as a full period after release.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam logic [15:0] SERVICE_ADDR = 16'hFFFF;
  localparam logic [14:0] VECTOR_PAGE  = 15'h7FFF; // 0xFFFE and 0xFFFF
endpackage

// File: rtl/cop_bus_decode.sv
module cop_bus_decode
  import cop_pkg::*;
(
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        vec_fetch,
  output logic        service,
  output logic        vec_clear,
  output logic        vec_read
);
  logic hit_top;
  assign hit_top   = (bus_addr == SERVICE_ADDR);
  assign service   = bus_wr & hit_top;
  assign vec_read  = bus_rd & hit_top;
  assign vec_clear = vec_fetch & (bus_addr[15:1] == VECTOR_PAGE);
endmodule

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
  parameter int PRESCALE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [PRESCALE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (clr || !en) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  assign tick = en & ~clr & (&pre_q);
endmodule

// File: rtl/cop_timeout.sv
module cop_timeout #(
  parameter int SHORT_EXP = 13,
  parameter int LONG_EXP  = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic sel_long,
  output logic expire
);
  localparam logic [LONG_EXP-1:0] SHORT_LAST = LONG_EXP'((64'd1 << SHORT_EXP) - 1);
  localparam logic [LONG_EXP-1:0] LONG_LAST  = '1;

  logic [LONG_EXP-1:0] cnt_q;
  logic [LONG_EXP-1:0] last;

  assign last   = sel_long ? LONG_LAST : SHORT_LAST;
  assign expire = tick & ~clr & (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int          PRESCALE_W = 4,
  parameter int          SHORT_EXP  = 13,
  parameter int          LONG_EXP   = 18,
  parameter logic [7:0]  VEC_LO     = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        vec_fetch,
  input  logic        cfg_disable,
  input  logic        cfg_long,
  input  logic        monitor_mode,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        cop_reset
);
  logic service, vec_clear, vec_read;
  logic active, self_clr, tick, expire;
  logic reset_q, rdv_q;

  cop_bus_decode u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .vec_fetch(vec_fetch),
    .service  (service),
    .vec_clear(vec_clear),
    .vec_read (vec_read)
  );

  assign active   = ~cfg_disable & ~monitor_mode;
  assign self_clr = reset_q;

  cop_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (self_clr | vec_clear),
    .en   (active),
    .tick (tick)
  );

  cop_timeout #(.SHORT_EXP(SHORT_EXP), .LONG_EXP(LONG_EXP)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (self_clr | ~active | service),
    .tick    (tick),
    .sel_long(cfg_long),
    .expire  (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_q <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      reset_q <= expire;
      rdv_q   <= vec_read;
    end
  end

  assign cop_reset = reset_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdv_q ? VEC_LO : 8'h00;
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter logic [7:0] VEC_LO = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        cfg_disable,
  input logic        monitor_mode,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic        cop_reset
);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cop_reset |=> !cop_reset);

  assert_serviced_no_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 16'hFFFF) |=> !cop_reset);

  assert_read_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 16'hFFFF) |=> (rd_valid && rd_data == VEC_LO));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> !cop_reset);

  assert_monitor_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    monitor_mode |=> !cop_reset);

  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (!cop_reset && !rd_valid);
  end
endmodule

bind cop_watchdog cop_watchdog_chk #(.VEC_LO(VEC_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .cfg_disable(cfg_disable), .monitor_mode(monitor_mode),
  .rd_data(rd_data), .rd_valid(rd_valid), .cop_reset(cop_reset)
);

// File: tb/test_cop_watchdog.sv
`timescale 1ns/1ps
module test_cop_watchdog;
  localparam int PW = 2, SE = 5, LE = 8;
  localparam logic [7:0] VLO = 8'hA7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic bus_rd = 0, bus_wr = 0, vec_fetch = 0, cfg_disable = 0, cfg_long = 0, monitor_mode = 0;
  logic [7:0] rd_data;
  logic rd_valid, cop_reset;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cop_watchdog #(.PRESCALE_W(PW), .SHORT_EXP(SE), .LONG_EXP(LE), .VEC_LO(VLO)) i_cop_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .vec_fetch(vec_fetch), .cfg_disable(cfg_disable), .cfg_long(cfg_long),
    .monitor_mode(monitor_mode), .rd_data(rd_data), .rd_valid(rd_valid), .cop_reset(cop_reset)
  );

  function automatic int period(bit lng);
    return (1 << PW) * (1 << (lng ? LE : SE));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  logic [PW-1:0] m_pre = '0;
  logic [LE-1:0] m_cnt = '0;
  logic m_rst = 0, m_rdv = 0;
  logic m_act, m_vclr, m_svc, m_tick, m_clr;
  logic [LE-1:0] m_last;
  assign m_act  = !cfg_disable && !monitor_mode;
  assign m_vclr = vec_fetch && (bus_addr == 16'hFFFE || bus_addr == 16'hFFFF);
  assign m_svc  = bus_wr && bus_addr == 16'hFFFF;
  assign m_clr  = m_rst;
  assign m_tick = m_act && !m_clr && !m_vclr && (m_pre == {PW{1'b1}});
  assign m_last = cfg_long ? {LE{1'b1}} : LE'((1 << SE) - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= '0; m_cnt <= '0; m_rst <= 0; m_rdv <= 0;
    end else begin
      m_pre <= (m_clr || m_vclr || !m_act) ? '0 : m_pre + 1'b1;
      if (m_clr || !m_act || m_svc) m_cnt <= '0;
      else if (m_tick)              m_cnt <= m_cnt + 1'b1;
      m_rst <= m_tick && !m_clr && m_act && !m_svc && (m_cnt >= m_last);
      m_rdv <= bus_rd && bus_addr == 16'hFFFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cop_reset == m_rst, "R2/R3/R9 cop_reset vs model", cop_reset, m_rst);
      chk(rd_valid == m_rdv, "R5 rd_valid vs model", rd_valid, m_rdv);
      if (rd_valid) chk(rd_data == VLO, "R5 rd_data", rd_data, VLO);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_rd = 0; bus_wr = 0; vec_fetch = 0;
    repeat (2) @(negedge clk);
    chk(!cop_reset && !rd_valid, "R1 outputs in reset", {cop_reset, rd_valid}, 0);
    rst_n = 1;
  endtask

  // kind: 0 idle, 1 write FFFF /100, 2 write FFFE /100, 3 read FFFF each cycle,
  //       4 vec fetch FFFE /3, 5 vec fetch 1234 /3. Returns edges until pulse (0 = none).
  task automatic run(int kind, int maxn, output int hit);
    hit = 0;
    for (int i = 1; i <= maxn; i++) begin
      bus_wr = 0; bus_rd = 0; vec_fetch = 0; bus_addr = 16'h0;
      case (kind)
        1: if (i % 100 == 0) begin bus_wr = 1; bus_addr = 16'hFFFF; end
        2: if (i % 100 == 0) begin bus_wr = 1; bus_addr = 16'hFFFE; end
        3: begin bus_rd = 1; bus_addr = 16'hFFFF; end
        4: if (i % 3 == 0) begin vec_fetch = 1; bus_addr = 16'hFFFE; end
        5: if (i % 3 == 0) begin vec_fetch = 1; bus_addr = 16'h1234; end
        default: ;
      endcase
      @(negedge clk);
      if (cop_reset) begin hit = i; break; end
    end
    bus_wr = 0; bus_rd = 0; vec_fetch = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd2718));
    do_reset();
    run(0, 5000, n); chk(n == period(0), "R2 short period edges", n, period(0));
    @(negedge clk); chk(!cop_reset, "R2 pulse one cycle wide", cop_reset, 0);
    run(0, 5000, n); chk(n == period(0), "R9 restart after own pulse", n + 1, period(0) + 1);
    cfg_long = 1; do_reset();
    run(0, 5000, n); chk(n == period(1), "R3 long period edges", n, period(1));
    cfg_long = 0; do_reset();
    run(1, 1000, n); chk(n == 0, "R4 serviced no pulse", n, 0);
    do_reset();
    run(2, 1000, n); chk(n == period(0), "R10 write elsewhere ignored", n, period(0));
    do_reset();
    run(3, 1000, n); chk(n == period(0), "R5 reads do not service", n, period(0));
    do_reset();
    run(4, 1000, n); chk(n == 0, "R6 vec fetch clears prescaler", n, 0);
    do_reset();
    run(5, 1000, n); chk(n == period(0), "R6 vec fetch elsewhere ignored", n, period(0));
    do_reset();
    cfg_disable = 1; run(0, 2000, n); chk(n == 0, "R7 disabled no pulse", n, 0);
    cfg_disable = 0; run(0, 5000, n); chk(n == period(0), "R7 full period after enable", n, period(0));
    monitor_mode = 1; run(0, 2000, n); chk(n == 0, "R8 monitor no pulse", n, 0);
    monitor_mode = 0; run(0, 5000, n); chk(n == period(0), "R8 full period after exit", n, period(0));
    do_reset();
    for (int i = 0; i < 30000; i++) begin
      bus_addr  = ($urandom % 4 == 0) ? 16'hFFFF : (($urandom % 2 == 1) ? 16'hFFFE : 16'($urandom));
      bus_wr    = ($urandom % 300 == 0);
      bus_rd    = ($urandom % 8 == 0);
      vec_fetch = ($urandom % 500 == 0);
      if ($urandom % 3000 == 0) cfg_disable  = ~cfg_disable;
      if ($urandom % 4000 == 0) monitor_mode = ~monitor_mode;
      if ($urandom % 2000 == 0) cfg_long     = ~cfg_long;
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule